// File: doc/BRIEF.md
# ATA Task-File Register Bank

This block holds the byte-wide command registers of an ATA-style storage device. It also covers the alternate status/control location beside them. A host reaches the eight registers through a 3-bit address with one-cycle read and write strobes. It programs the sector count, starting sector, cylinder and drive/head fields, then writes a command byte.

The block checks whether the selected drive can take the command. A rejected command is aborted locally. An accepted command goes to a separate executor as a one-cycle strobe. The strobe carries the command code, the drive, the feature byte, the sector count (0 stands for 256) and the byte offset worked out from the cylinder/head/sector geometry.

The block builds the status byte from drive presence, from the data-buffer flags that the executor supplies, and from the error register. It drives a level interrupt. A completion or an abort starts a short countdown, and the interrupt rises when the countdown expires. Reading the status register drops the interrupt. Reading the alternate status has no such side effect. After a soft reset through the control register, a packet-capable drive shows its signature in the cylinder registers.

Top module: `ata_taskfile_regs`

## Requirements
- R1: After a write, a read returns the stored byte for sector count (address 2), sector (address 3), cylinder low (address 4) and cylinder high (address 5). Address 0 always reads 0x00.
- R2: A write to address 6 is split into sector size (bits 7:6), LBA (bit 5), drive select (bit 4) and head (bits 3:0). A read of address 6 returns the same byte.
- R3: The status byte is read at address 7 and at `alt_status`. It has bit 6 and bit 4 set when the selected drive is present. Bit 3 is set when `fifo_empty` is low or `write_pending` is high. Bit 0 is set when the error register is non-zero. All other bits read 0.
- R4: A read of address 1 returns the error register, and the register is 0x00 from the next cycle on.
- R5: A command write (address 7) to a present drive that is not aborted raises `cmd_strobe` for exactly the next cycle. With the strobe come the command code, the drive select, the byte last written to address 1, and `cmd_count`, which equals the sector count or 256 when that count is 0. The same write clears the error register.
- R6: With the strobe, `cmd_offset` equals 512 × ((sector − 1) + head × spt + heads × spt × (high × 256 + low)), modulo 2^OFF_W. The heads and spt values are those of the selected drive.
- R7: A command write to an absent drive, or command 0xEC to a drive flagged as a packet device, raises no strobe. It sets the error register to 0x04 and starts the interrupt countdown.
- R8: An abort or a `cmd_done` pulse loads the countdown. With the default delay of 1, `irq` rises at the second clock edge after that event and stays high until status is read.
- R9: A read of address 7 drops `irq` at the next edge and cancels a pending countdown. A read of any other address leaves `irq` unchanged.
- R10: A control write with bit 2 set enters the reset state. A control write with bit 2 clear has no effect on it. In the reset state, addresses 4 and 5 read 0x14 and 0xEB while the selected drive is a packet device. The next command write leaves the reset state.
- R11: After reset, all registers read 0x00, and `irq` and `cmd_strobe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (carries side effects) |
| wr_data | input | 8 | Write data for registers and control |
| rd_data | output | 8 | Read data for `reg_addr` (combinational) |
| alt_wr | input | 1 | Control register write strobe |
| alt_status | output | 8 | Status byte without read side effects |
| drive_present | input | 2 | Per-drive presence |
| drive_is_packet | input | 2 | Per-drive packet-device flag |
| heads_d0 | input | HEADS_W | Head count of drive 0 |
| spt_d0 | input | SPT_W | Sectors per track of drive 0 |
| heads_d1 | input | HEADS_W | Head count of drive 1 |
| spt_d1 | input | SPT_W | Sectors per track of drive 1 |
| fifo_empty | input | 1 | Data buffer holds no bytes |
| write_pending | input | 1 | Executor awaits write data |
| cmd_done | input | 1 | Executor completion pulse |
| cmd_strobe | output | 1 | One-cycle command issue |
| cmd_code | output | 8 | Issued command code |
| cmd_drive | output | 1 | Issued drive select |
| cmd_feature | output | 8 | Feature byte (address 1 write) |
| cmd_count | output | 9 | Sector count, 1 to 256 |
| cmd_offset | output | OFF_W | Byte offset from CHS geometry |
| irq | output | 1 | Interrupt request level |

## Verification
Some rules can be checked on every cycle. These are that a status read drops the interrupt by the next edge, that a raised interrupt holds until status is read, that a strobe only follows a command write, that a command to an absent drive ends in ERR with no strobe, that reading the error register clears ERR, and that DRQ follows the buffer flags. The scenarios are needed for the rest: the exact timing of the countdown, a pending interrupt being cancelled by a status read in the very cycle it would expire, the CHS offset and the 0-means-256 count, the packet-device signature after a soft reset, and the register readback layout.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  typedef enum logic [2:0] {
    TF_DATA = 3'd0, TF_ERRFEAT = 3'd1, TF_COUNT = 3'd2, TF_SECTOR = 3'd3,
    TF_CYL_LO = 3'd4, TF_CYL_HI = 3'd5, TF_DRVHEAD = 3'd6, TF_STATCMD = 3'd7
  } tf_addr_e;

  typedef struct packed {
    logic [1:0] sec_size;
    logic       lba;
    logic       drv;
    logic [3:0] head;
  } drvhead_t;

  localparam logic [7:0] ST_READY    = 8'h40;
  localparam logic [7:0] ST_SEEKDONE = 8'h10;
  localparam logic [7:0] ST_DATAREQ  = 8'h08;
  localparam logic [7:0] ST_ERROR    = 8'h01;
  localparam logic [7:0] ERR_ABORT   = 8'h04;
  localparam logic [7:0] OP_IDENTIFY = 8'hEC;
  localparam int         CTL_RST_BIT = 2;
  localparam logic [7:0] SIG_CYL_LO  = 8'h14;
  localparam logic [7:0] SIG_CYL_HI  = 8'hEB;
endpackage

// File: rtl/ata_tf_status.sv
module ata_tf_status
  import ata_tf_pkg::*;
(
  input  logic       sel_present,
  input  logic       fifo_empty,
  input  logic       write_pending,
  input  logic [7:0] err_val,
  output logic [7:0] status
);
  always_comb begin
    status = 8'h00;
    if (sel_present)                 status = status | ST_READY | ST_SEEKDONE;
    if (!fifo_empty || write_pending) status = status | ST_DATAREQ;
    if (err_val != 8'h00)            status = status | ST_ERROR;
  end
endmodule

// File: rtl/ata_tf_irq.sv
module ata_tf_irq #(
  parameter int INT_DELAY = 1,
  localparam int CNT_W = $clog2(INT_DELAY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic clear,
  output logic irq
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             irq_q, irq_n;

  always_comb begin
    cnt_n = cnt_q;
    irq_n = irq_q;
    if (cnt_q != '0)               cnt_n = cnt_q - 1'b1;
    if (cnt_q == CNT_W'(1))        irq_n = 1'b1;
    if (clear) begin
      cnt_n = '0;
      irq_n = 1'b0;
    end
    if (load)                      cnt_n = CNT_W'(INT_DELAY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      irq_q <= irq_n;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/ata_tf_chs.sv
module ata_tf_chs #(
  parameter int HEADS_W = 5,
  parameter int SPT_W   = 8,
  parameter int OFF_W   = 39
) (
  input  logic [15:0]        cyl,
  input  logic [3:0]         head,
  input  logic [7:0]         sector,
  input  logic [HEADS_W-1:0] heads,
  input  logic [SPT_W-1:0]   spt,
  output logic [OFF_W-1:0]   offset
);
  logic [OFF_W-1:0] lin;

  always_comb begin
    lin = OFF_W'(sector) - OFF_W'(1)
        + OFF_W'(head) * OFF_W'(spt)
        + OFF_W'(heads) * OFF_W'(spt) * OFF_W'(cyl);
    offset = {lin[OFF_W-10:0], 9'b0};
  end
endmodule

// File: rtl/ata_taskfile_regs.sv
module ata_taskfile_regs
  import ata_tf_pkg::*;
#(
  parameter int HEADS_W   = 5,
  parameter int SPT_W     = 8,
  parameter int INT_DELAY = 1,
  localparam int OFF_W    = 9 + 16 + HEADS_W + SPT_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [7:0]         wr_data,
  output logic [7:0]         rd_data,
  input  logic               alt_wr,
  output logic [7:0]         alt_status,
  input  logic [1:0]         drive_present,
  input  logic [1:0]         drive_is_packet,
  input  logic [HEADS_W-1:0] heads_d0,
  input  logic [SPT_W-1:0]   spt_d0,
  input  logic [HEADS_W-1:0] heads_d1,
  input  logic [SPT_W-1:0]   spt_d1,
  input  logic               fifo_empty,
  input  logic               write_pending,
  input  logic               cmd_done,
  output logic               cmd_strobe,
  output logic [7:0]         cmd_code,
  output logic               cmd_drive,
  output logic [7:0]         cmd_feature,
  output logic [8:0]         cmd_count,
  output logic [OFF_W-1:0]   cmd_offset,
  output logic               irq
);
  logic [7:0] err_q, err_n, feat_q, cnt_q, sec_q, clo_q, chi_q;
  drvhead_t   dh_q;
  logic       srst_q, srst_n;
  logic       strobe_q;
  logic [7:0] code_q, feat_o_q;
  logic       drv_o_q;
  logic [8:0] count_q;
  logic [OFF_W-1:0] off_q, off_calc;

  logic wr_cmd, rd_err, rd_stat, sel_present, sel_packet, abort, accept;
  logic [HEADS_W-1:0] heads_sel;
  logic [SPT_W-1:0]   spt_sel;
  logic [7:0]         status;

  assign wr_cmd      = reg_wr && (reg_addr == TF_STATCMD);
  assign rd_err      = reg_rd && (reg_addr == TF_ERRFEAT);
  assign rd_stat     = reg_rd && (reg_addr == TF_STATCMD);
  assign sel_present = drive_present[dh_q.drv];
  assign sel_packet  = drive_is_packet[dh_q.drv];
  assign abort       = wr_cmd && (!sel_present || (sel_packet && wr_data == OP_IDENTIFY));
  assign accept      = wr_cmd && !abort;
  assign heads_sel   = dh_q.drv ? heads_d1 : heads_d0;
  assign spt_sel     = dh_q.drv ? spt_d1 : spt_d0;

  ata_tf_status u_status (
    .sel_present   (sel_present),
    .fifo_empty    (fifo_empty),
    .write_pending (write_pending),
    .err_val       (err_q),
    .status        (status)
  );

  ata_tf_chs #(.HEADS_W(HEADS_W), .SPT_W(SPT_W), .OFF_W(OFF_W)) u_chs (
    .cyl    ({chi_q, clo_q}),
    .head   (dh_q.head),
    .sector (sec_q),
    .heads  (heads_sel),
    .spt    (spt_sel),
    .offset (off_calc)
  );

  ata_tf_irq #(.INT_DELAY(INT_DELAY)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (abort || cmd_done),
    .clear (rd_stat),
    .irq   (irq)
  );

  // next-state for error and reset-state flags
  always_comb begin
    err_n = err_q;
    if (wr_cmd)      err_n = abort ? ERR_ABORT : 8'h00;
    else if (rd_err) err_n = 8'h00;
    srst_n = srst_q;
    if (wr_cmd)                            srst_n = 1'b0;
    else if (alt_wr && wr_data[CTL_RST_BIT]) srst_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 8'h00;
      srst_q <= 1'b0;
      feat_q <= 8'h00;
      cnt_q  <= 8'h00;
      sec_q  <= 8'h00;
      clo_q  <= 8'h00;
      chi_q  <= 8'h00;
      dh_q   <= '0;
    end else begin
      err_q  <= err_n;
      srst_q <= srst_n;
      if (reg_wr && reg_addr == TF_ERRFEAT) feat_q <= wr_data;
      if (reg_wr && reg_addr == TF_COUNT)   cnt_q  <= wr_data;
      if (reg_wr && reg_addr == TF_SECTOR)  sec_q  <= wr_data;
      if (reg_wr && reg_addr == TF_CYL_LO)  clo_q  <= wr_data;
      if (reg_wr && reg_addr == TF_CYL_HI)  chi_q  <= wr_data;
      if (reg_wr && reg_addr == TF_DRVHEAD) dh_q   <= drvhead_t'(wr_data);
    end
  end

  // command issue register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      code_q   <= 8'h00;
      feat_o_q <= 8'h00;
      drv_o_q  <= 1'b0;
      count_q  <= 9'd0;
      off_q    <= '0;
    end else begin
      strobe_q <= accept;
      if (accept) begin
        code_q   <= wr_data;
        feat_o_q <= feat_q;
        drv_o_q  <= dh_q.drv;
        count_q  <= (cnt_q == 8'h00) ? 9'd256 : {1'b0, cnt_q};
        off_q    <= off_calc;
      end
    end
  end

  always_comb begin
    unique case (tf_addr_e'(reg_addr))
      TF_DATA:     rd_data = 8'h00;
      TF_ERRFEAT:  rd_data = err_q;
      TF_COUNT:    rd_data = cnt_q;
      TF_SECTOR:   rd_data = sec_q;
      TF_CYL_LO:   rd_data = (srst_q && sel_packet) ? SIG_CYL_LO : clo_q;
      TF_CYL_HI:   rd_data = (srst_q && sel_packet) ? SIG_CYL_HI : chi_q;
      TF_DRVHEAD:  rd_data = dh_q;
      TF_STATCMD:  rd_data = status;
      default:     rd_data = 8'h00;
    endcase
  end

  assign alt_status  = status;
  assign cmd_strobe  = strobe_q;
  assign cmd_code    = code_q;
  assign cmd_drive   = drv_o_q;
  assign cmd_feature = feat_o_q;
  assign cmd_count   = count_q;
  assign cmd_offset  = off_q;
endmodule

// File: rtl/ata_tf_checker.sv
module ata_tf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] reg_addr,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [7:0] alt_status,
  input logic       fifo_empty,
  input logic       write_pending,
  input logic       sel_present,
  input logic       cmd_strobe,
  input logic       irq
);
  assert_status_read_drops_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd7) |=> !irq);

  assert_irq_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_rd && reg_addr == 3'd7)) |=> irq);

  assert_strobe_after_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |-> $past(reg_wr && reg_addr == 3'd7));

  assert_absent_aborts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd7 && !sel_present) |=> (!cmd_strobe && alt_status[0]));

  assert_err_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd1 && !(reg_wr && reg_addr == 3'd7)) |=> !alt_status[0]);

  assert_datareq_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_empty || write_pending) |-> alt_status[3]);
endmodule

bind ata_taskfile_regs ata_tf_checker u_tf_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_addr      (reg_addr),
  .reg_wr        (reg_wr),
  .reg_rd        (reg_rd),
  .alt_status    (alt_status),
  .fifo_empty    (fifo_empty),
  .write_pending (write_pending),
  .sel_present   (sel_present),
  .cmd_strobe    (cmd_strobe),
  .irq           (irq)
);

// File: tb/tb_ata_taskfile_regs.sv
`timescale 1ns/100ps
module tb_ata_taskfile_regs;
  localparam int HW = 5, SW = 8, OW = 9 + 16 + HW + SW + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] reg_addr;
  logic reg_wr, reg_rd, alt_wr, fifo_empty, write_pending, cmd_done;
  logic [7:0] wr_data, rd_data, alt_status, cmd_code, cmd_feature;
  logic [1:0] drive_present, drive_is_packet;
  logic [HW-1:0] heads_d0, heads_d1;
  logic [SW-1:0] spt_d0, spt_d1;
  logic cmd_strobe, cmd_drive, irq;
  logic [8:0] cmd_count;
  logic [OW-1:0] cmd_offset;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  ata_taskfile_regs dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .wr_data(wr_data), .rd_data(rd_data), .alt_wr(alt_wr), .alt_status(alt_status),
    .drive_present(drive_present), .drive_is_packet(drive_is_packet),
    .heads_d0(heads_d0), .spt_d0(spt_d0), .heads_d1(heads_d1), .spt_d1(spt_d1),
    .fifo_empty(fifo_empty), .write_pending(write_pending), .cmd_done(cmd_done),
    .cmd_strobe(cmd_strobe), .cmd_code(cmd_code), .cmd_drive(cmd_drive),
    .cmd_feature(cmd_feature), .cmd_count(cmd_count), .cmd_offset(cmd_offset), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  int m_err, m_feat, m_cnt, m_sec, m_clo, m_chi, m_dh, m_srst;
  int m_strobe, m_code, m_drv, m_featout, m_count, m_delay, m_irq;
  longint m_off;
  localparam longint OMASK = (longint'(1) << OW) - 1;

  function automatic int drv_sel();
    return (m_dh >> 4) & 1;
  endfunction

  function automatic int exp_status();
    int s = 0;
    if (drive_present[drv_sel()]) s |= 'h50;
    if (!fifo_empty || write_pending) s |= 'h08;
    if (m_err != 0) s |= 'h01;
    return s;
  endfunction

  function automatic int exp_rd();
    bit sig = (m_srst != 0) && drive_is_packet[drv_sel()];
    case (reg_addr)
      3'd1: return m_err;
      3'd2: return m_cnt;
      3'd3: return m_sec;
      3'd4: return sig ? 'h14 : m_clo;
      3'd5: return sig ? 'hEB : m_chi;
      3'd6: return m_dh;
      3'd7: return exp_status();
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_err = 0; m_feat = 0; m_cnt = 0; m_sec = 0; m_clo = 0; m_chi = 0; m_dh = 0;
      m_srst = 0; m_strobe = 0; m_code = 0; m_drv = 0; m_featout = 0; m_count = 0;
      m_off = 0; m_delay = 0; m_irq = 0;
    end else begin
      bit cmdw, ab, present;
      int d, hd, sp, cyl, nd, ni;
      cmdw = reg_wr && reg_addr == 7;
      d = drv_sel();
      present = drive_present[d];
      ab = cmdw && (!present || (drive_is_packet[d] && wr_data == 8'hEC));
      // interrupt countdown
      nd = (m_delay > 0) ? m_delay - 1 : 0;
      ni = (m_delay == 1) ? 1 : m_irq;
      if (reg_rd && reg_addr == 7) begin nd = 0; ni = 0; end
      if (ab || cmd_done) nd = 1;
      m_delay = nd; m_irq = ni;
      // command issue
      m_strobe = cmdw && !ab;
      if (cmdw && !ab) begin
        hd = d ? heads_d1 : heads_d0;
        sp = d ? spt_d1 : spt_d0;
        cyl = m_chi * 256 + m_clo;
        m_code = wr_data; m_featout = m_feat; m_drv = d;
        m_count = (m_cnt == 0) ? 256 : m_cnt;
        m_off = (512 * (longint'(m_sec) - 1 + longint'(m_dh & 15) * sp
                 + longint'(hd) * sp * cyl)) & OMASK;
      end
      if (cmdw) m_err = ab ? 4 : 0;
      else if (reg_rd && reg_addr == 1) m_err = 0;
      if (cmdw) m_srst = 0;
      else if (alt_wr && wr_data[2]) m_srst = 1;
      if (reg_wr) case (reg_addr)
        3'd1: m_feat = wr_data;
        3'd2: m_cnt = wr_data;
        3'd3: m_sec = wr_data;
        3'd4: m_clo = wr_data;
        3'd5: m_chi = wr_data;
        3'd6: m_dh = wr_data;
        default: ;
      endcase
    end
  end

  task automatic chk(input string tag, input longint got, input longint exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=0x%0h exp=0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8 irq vs model", irq, m_irq);
      chk("R5 strobe vs model", cmd_strobe, m_strobe);
      chk("R3 alt_status vs model", alt_status, exp_status());
      chk("R1 rd_data vs model", rd_data, exp_rd());
      if (cmd_strobe) begin
        chk("R5 code vs model", cmd_code, m_code);
        chk("R5 count vs model", cmd_count, m_count);
        chk("R5 feature vs model", cmd_feature, m_featout);
        chk("R5 drive vs model", cmd_drive, m_drv);
        chk("R6 offset vs model", cmd_offset, m_off);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle();
    reg_wr = 0; reg_rd = 0; alt_wr = 0; cmd_done = 0; reg_addr = 0; wr_data = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); #1; reg_wr = 1; reg_addr = a; wr_data = d;
    @(negedge clk); #1; idle();
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); #1; reg_rd = 1; reg_addr = a; #0.5; v = rd_data;
    @(negedge clk); #1; idle();
  endtask

  task automatic ctl(input logic [7:0] d);
    @(negedge clk); #1; alt_wr = 1; wr_data = d;
    @(negedge clk); #1; idle();
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); #1; reg_addr = a; #0.5; v = rd_data;
    @(negedge clk); #1; idle();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    idle();
    drive_present = 2'b01; drive_is_packet = 2'b00;
    heads_d0 = 5'd4; spt_d0 = 8'd17; heads_d1 = 5'd16; spt_d1 = 8'd63;
    fifo_empty = 1; write_pending = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;

    // R11 reset state
    chk("R11 irq after reset", irq, 0);
    chk("R11 strobe after reset", cmd_strobe, 0);
    rd(3'd2, v); chk("R11 count after reset", v, 8'h00);
    rd(3'd6, v); chk("R11 drive/head after reset", v, 8'h00);
    rd(3'd7, v); chk("R3 status drive0 present", v, 8'h50);

    // R1 register readback
    wr(3'd2, 8'h00); wr(3'd3, 8'h03); wr(3'd4, 8'h02); wr(3'd5, 8'h01);
    rd(3'd3, v); chk("R1 sector readback", v, 8'h03);
    rd(3'd4, v); chk("R1 cyl low readback", v, 8'h02);
    rd(3'd5, v); chk("R1 cyl high readback", v, 8'h01);
    rd(3'd0, v); chk("R1 data address reads zero", v, 8'h00);

    // R2 drive/head layout
    wr(3'd6, 8'hA5);
    rd(3'd6, v); chk("R2 drive/head readback", v, 8'hA5);
    wr(3'd6, 8'h02);   // drive 0, head 2

    // R5/R6 accepted command, count 0 -> 256
    wr(3'd1, 8'h3C);
    wr(3'd7, 8'h20);
    chk("R5 strobe one cycle", cmd_strobe, 1);
    chk("R5 code", cmd_code, 8'h20);
    chk("R5 count 0 means 256", cmd_count, 9'd256);
    chk("R5 feature", cmd_feature, 8'h3C);
    chk("R6 chs offset", cmd_offset, longint'(17580) * 512);
    @(negedge clk); #1;
    chk("R5 strobe drops", cmd_strobe, 0);

    // R8 completion countdown
    @(negedge clk); #1; cmd_done = 1;
    @(negedge clk); #1; cmd_done = 0;
    chk("R8 irq not yet", irq, 0);
    @(negedge clk); #1;
    chk("R8 irq raised", irq, 1);
    rd(3'd1, v); chk("R9 other read keeps irq", irq, 1);
    rd(3'd7, v); chk("R9 status read drops irq", irq, 0);

    // R9 cancel of a pending countdown
    @(negedge clk); #1; cmd_done = 1;
    @(negedge clk); #1; cmd_done = 0; reg_rd = 1; reg_addr = 3'd7;
    @(negedge clk); #1; idle();
    repeat (3) @(negedge clk);
    #1 chk("R9 pending countdown cancelled", irq, 0);

    // R7 abort on absent drive
    wr(3'd6, 8'h10);
    wr(3'd7, 8'h20);
    chk("R7 no strobe on abort", cmd_strobe, 0);
    chk("R7 ERR bit on abort", alt_status[0], 1);
    @(negedge clk); #1;
    chk("R7 abort raises irq", irq, 1);
    rd(3'd1, v); chk("R4 error value", v, 8'h04);
    rd(3'd1, v); chk("R4 error cleared by read", v, 8'h00);
    rd(3'd7, v);

    // R7 identify to packet drive; other command accepted
    drive_present = 2'b11; drive_is_packet = 2'b10;
    wr(3'd7, 8'hEC);
    chk("R7 identify to packet: no strobe", cmd_strobe, 0);
    rd(3'd1, v); chk("R7 identify to packet: abort code", v, 8'h04);
    wr(3'd2, 8'h05);
    wr(3'd7, 8'hA1);
    chk("R5 packet identify accepted", cmd_strobe, 1);
    chk("R5 drive 1 issued", cmd_drive, 1);
    chk("R5 plain count", cmd_count, 9'd5);
    rd(3'd7, v);

    // R10 soft reset signature
    ctl(8'h04);
    peek(3'd4, v); chk("R10 signature low", v, 8'h14);
    peek(3'd5, v); chk("R10 signature high", v, 8'hEB);
    wr(3'd6, 8'h00);
    peek(3'd4, v); chk("R10 non-packet drive shows stored low", v, 8'h02);
    wr(3'd6, 8'h10);
    wr(3'd7, 8'h00);
    peek(3'd5, v); chk("R10 command leaves reset state", v, 8'h01);
    ctl(8'h02);
    peek(3'd4, v); chk("R10 control without bit 2 ignored", v, 8'h02);
    rd(3'd7, v);

    // R3 data request flag
    fifo_empty = 0;
    @(negedge clk); #1 chk("R3 DRQ from buffer", alt_status[3], 1);
    fifo_empty = 1; write_pending = 1;
    @(negedge clk); #1 chk("R3 DRQ from write pending", alt_status[3], 1);
    write_pending = 0;
    @(negedge clk); #1 chk("R3 DRQ clear", alt_status[3], 0);

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule